// File: doc/BRIEF.md
# Packet Queue Interrupt Generator

This block turns the occupancy of three packet-number queues into host interrupt status. The queues are a receive-done queue, a transmit-pending queue and a transmit-completion queue. The host never has to read a per-packet status register before the controller moves to the next queued packet, because transmit and receive results stay in packet memory. Each status bit is a pure level. A bit stays set for as long as its queue condition holds, so one service pass can drain several packets. A bit drops only when that condition goes away. Writing a register never clears it.

The status bits are ANDed with an 8-bit enable mask and ORed into a single registered interrupt line. The block also handles auto-release for each finished transmit:
- **Auto-release off:** every finished transmit posts a completion entry, which gives one interrupt per packet.
- **Auto-release on:** a successful transmit releases its buffer and posts nothing. Only a failed transmit posts a completion, and the host uses the transmit-empty bit to detect the end of a batch.

The transmit-empty bit is gated by a small state machine so that an empty pending queue at start-up raises nothing:
- **States:** `TXE_OFF` (the enable bit is clear), `TXE_WAIT` (enabled, but no packet queued yet) and `TXE_ARMED` (a packet has been queued since the bit was enabled).
- **Transitions:** `OFF->WAIT` when the enable bit is set. `WAIT->ARMED` when the pending count is non-zero. `WAIT->OFF` and `ARMED->OFF` when the enable bit is cleared. In every other case the state holds.
- **Flag:** the transmit-empty condition is raised only in `TXE_ARMED`, with the enable bit set and the pending count zero.

Top module: `pktq_irq_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `status_o`, `mask_o`, `irq_o`, `cmpl_push_o` and `buf_release_o` are all zero.
- R2: Status bit 0 (receive) equals "receive-done count non-zero" as sampled at the previous clock edge.
- R3: Status bit 1 (transmit) equals "completion count non-zero" as sampled at the previous clock edge.
- R4: Status bit 2 (transmit-empty) is 1 only if, at the previous edge, mask bit 2 was set, the pending count was zero, and a non-zero pending count had been seen at an earlier edge while the machine was in `TXE_WAIT` after mask bit 2 was enabled.
- R5: `irq_o` equals the OR over all bits of (previous-edge status conditions AND previous-edge mask), so it changes one clock after a queue change.
- R6: Status bits 7..3 are always zero. A mask write does not clear any status bit.
- R7: With auto-release off, each `tx_done_i` pulse gives a `cmpl_push_o` pulse one clock later, and `buf_release_o` stays 0.
- R8: With auto-release on, a pulse with `tx_ok_i`=1 gives `buf_release_o` one clock later, and a pulse with `tx_ok_i`=0 gives `cmpl_push_o` one clock later. The two outputs are never high together.
- R9: Clearing mask bit 2 returns the machine to `TXE_OFF`. After re-enabling, transmit-empty stays 0 until a new non-zero pending count is seen.
- R10: `mask_o` shows the last value written with `mask_we_i`, from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_cnt_i | input | CNT_W | Receive-done queue occupancy |
| txp_cnt_i | input | CNT_W | Transmit-pending queue occupancy |
| txc_cnt_i | input | CNT_W | Transmit-completion queue occupancy |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| auto_rel_i | input | 1 | Auto-release enable |
| tx_done_i | input | 1 | One-cycle pulse: a transmit finished |
| tx_ok_i | input | 1 | Result of the finished transmit (1 = success) |
| status_o | output | 8 | Registered level status (bit0 rx, bit1 tx, bit2 tx-empty) |
| mask_o | output | 8 | Mask register readback |
| irq_o | output | 1 | Registered combined interrupt |
| cmpl_push_o | output | 1 | Push request to the completion queue |
| buf_release_o | output | 1 | Buffer release request |

## Verification
A wrong arming state shows up at `status_o[2]` and `irq_o` exactly one clock after the pending count drops to zero. Either a spurious assertion appears at start-up, or the flag fails to appear after a batch. A mask register that is corrupted or cleared by a write shows on `mask_o` and `irq_o` one clock after the write. A wrong auto-release decision shows on the push/release pulses one clock after `tx_done_i`. Because every output is a registered level, any divergence is visible within one cycle of the stimulus that exposes it.

// File: rtl/pktq_irq_pkg.sv
package pktq_irq_pkg;
    localparam int ST_W    = 8;
    localparam int IDX_RX  = 0;
    localparam int IDX_TX  = 1;
    localparam int IDX_TXE = 2;
    localparam int USED_W  = 3;

    typedef enum logic [1:0] {
        TXE_OFF   = 2'd0,
        TXE_WAIT  = 2'd1,
        TXE_ARMED = 2'd2
    } txe_state_e;
endpackage

// File: rtl/pktq_txe_fsm.sv
module pktq_txe_fsm
    import pktq_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic pend_empty_i,
    output logic txe_lvl_o
);
    txe_state_e state_q;
    txe_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TXE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXE_OFF: begin
                if (enable_i) state_d = TXE_WAIT;
            end
            TXE_WAIT: begin
                if (!enable_i)         state_d = TXE_OFF;
                else if (!pend_empty_i) state_d = TXE_ARMED;
            end
            TXE_ARMED: begin
                if (!enable_i) state_d = TXE_OFF;
            end
            default: state_d = TXE_OFF;
        endcase
    end

    // output
    always_comb begin
        txe_lvl_o = 1'b0;
        unique case (state_q)
            TXE_OFF:   txe_lvl_o = 1'b0;
            TXE_WAIT:  txe_lvl_o = 1'b0;
            TXE_ARMED: txe_lvl_o = enable_i && pend_empty_i;
            default:   txe_lvl_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pktq_autorel.sv
module pktq_autorel (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_rel_i,
    input  logic tx_done_i,
    input  logic tx_ok_i,
    output logic cmpl_push_o,
    output logic buf_release_o
);
    logic push_d;
    logic rel_d;

    always_comb begin
        rel_d  = tx_done_i && auto_rel_i && tx_ok_i;
        push_d = tx_done_i && !(auto_rel_i && tx_ok_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmpl_push_o   <= 1'b0;
            buf_release_o <= 1'b0;
        end else begin
            cmpl_push_o   <= push_d;
            buf_release_o <= rel_d;
        end
    end
endmodule

// File: rtl/pktq_irq_core.sv
module pktq_irq_core
    import pktq_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic [CNT_W-1:0] txc_cnt_i,
    input  logic             txe_lvl_i,
    input  logic             mask_we_i,
    input  logic [ST_W-1:0]  mask_wdata_i,
    output logic [ST_W-1:0]  mask_o,
    output logic [ST_W-1:0]  status_o,
    output logic             irq_o
);
    logic [ST_W-1:0] lvl;
    logic [ST_W-1:0] mask_q;

    always_comb begin
        lvl          = '0;
        lvl[IDX_RX]  = (rx_cnt_i != '0);
        lvl[IDX_TX]  = (txc_cnt_i != '0);
        lvl[IDX_TXE] = txe_lvl_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            status_o <= '0;
            irq_o    <= 1'b0;
        end else begin
            if (mask_we_i) mask_q <= mask_wdata_i;
            status_o <= lvl;
            irq_o    <= |(lvl & mask_q);
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/pktq_irq_gen.sv
module pktq_irq_gen
    import pktq_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic [CNT_W-1:0] txp_cnt_i,
    input  logic [CNT_W-1:0] txc_cnt_i,
    input  logic             mask_we_i,
    input  logic [7:0]       mask_wdata_i,
    input  logic             auto_rel_i,
    input  logic             tx_done_i,
    input  logic             tx_ok_i,
    output logic [7:0]       status_o,
    output logic [7:0]       mask_o,
    output logic             irq_o,
    output logic             cmpl_push_o,
    output logic             buf_release_o
);
    logic txe_lvl;
    logic pend_empty;

    assign pend_empty = (txp_cnt_i == '0);

    pktq_txe_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (mask_o[IDX_TXE]),
        .pend_empty_i (pend_empty),
        .txe_lvl_o    (txe_lvl)
    );

    pktq_irq_core #(.CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_cnt_i     (rx_cnt_i),
        .txc_cnt_i    (txc_cnt_i),
        .txe_lvl_i    (txe_lvl),
        .mask_we_i    (mask_we_i),
        .mask_wdata_i (mask_wdata_i),
        .mask_o       (mask_o),
        .status_o     (status_o),
        .irq_o        (irq_o)
    );

    pktq_autorel u_rel (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_rel_i    (auto_rel_i),
        .tx_done_i     (tx_done_i),
        .tx_ok_i       (tx_ok_i),
        .cmpl_push_o   (cmpl_push_o),
        .buf_release_o (buf_release_o)
    );
endmodule

// File: rtl/pktq_irq_gen_chk.sv
module pktq_irq_gen_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] rx_cnt_i,
    input logic [CNT_W-1:0] txp_cnt_i,
    input logic [CNT_W-1:0] txc_cnt_i,
    input logic             auto_rel_i,
    input logic             tx_done_i,
    input logic             tx_ok_i,
    input logic [7:0]       status_o,
    input logic [7:0]       mask_o,
    input logic             irq_o,
    input logic             cmpl_push_o,
    input logic             buf_release_o
);
    p_rx_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[0] == ($past(rx_cnt_i) != '0)));

    p_tx_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[1] == ($past(txc_cnt_i) != '0)));

    p_txe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[2]) |-> ($past(mask_o[2]) && ($past(txp_cnt_i) == '0)));

    p_irq_combine_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |(status_o & $past(mask_o))));

    p_rsvd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7:3] == 5'd0);

    p_no_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_rel_i |=> !buf_release_o);

    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmpl_push_o && buf_release_o));

    p_fail_posts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_i && !tx_ok_i) |=> cmpl_push_o);
endmodule

bind pktq_irq_gen pktq_irq_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_cnt_i      (rx_cnt_i),
    .txp_cnt_i     (txp_cnt_i),
    .txc_cnt_i     (txc_cnt_i),
    .auto_rel_i    (auto_rel_i),
    .tx_done_i     (tx_done_i),
    .tx_ok_i       (tx_ok_i),
    .status_o      (status_o),
    .mask_o        (mask_o),
    .irq_o         (irq_o),
    .cmpl_push_o   (cmpl_push_o),
    .buf_release_o (buf_release_o)
);

// File: tb/pktq_irq_gen_bench.sv
module pktq_irq_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] rx_cnt = '0;
    logic [CNT_W-1:0] txp_cnt = '0;
    logic [CNT_W-1:0] txc_cnt = '0;
    logic             mask_we = 1'b0;
    logic [7:0]       mask_wdata = '0;
    logic             auto_rel = 1'b0;
    logic             tx_done = 1'b0;
    logic             tx_ok = 1'b0;
    logic [7:0]       status;
    logic [7:0]       mask;
    logic             irq;
    logic             cmpl_push;
    logic             buf_release;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected state
    int         m_st   = 0;   // 0 off, 1 waiting, 2 armed
    logic [7:0] m_mask = '0;
    logic [7:0] m_stat = '0;
    logic       m_irq  = 1'b0;
    logic       m_cp   = 1'b0;
    logic       m_br   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pktq_irq_gen #(.CNT_W(CNT_W)) u_pktq_irq_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_cnt_i      (rx_cnt),
        .txp_cnt_i     (txp_cnt),
        .txc_cnt_i     (txc_cnt),
        .mask_we_i     (mask_we),
        .mask_wdata_i  (mask_wdata),
        .auto_rel_i    (auto_rel),
        .tx_done_i     (tx_done),
        .tx_ok_i       (tx_ok),
        .status_o      (status),
        .mask_o        (mask),
        .irq_o         (irq),
        .cmpl_push_o   (cmpl_push),
        .buf_release_o (buf_release)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // level conditions from requirements R2, R3, R4
    function automatic logic [7:0] levels_now();
        logic [7:0] l = '0;
        l[0] = (rx_cnt != '0);
        l[1] = (txc_cnt != '0);
        l[2] = (m_st == 2) && m_mask[2] && (txp_cnt == '0);
        return l;
    endfunction

    function automatic int next_arm();
        if (!m_mask[2])                     return 0;
        if (m_st == 0)                      return 1;
        if (m_st == 1 && txp_cnt != '0)     return 2;
        return m_st;
    endfunction

    task automatic model_edge();
        logic [7:0] l;
        l      = levels_now();
        m_irq  = |(l & m_mask);
        m_stat = l;
        m_cp   = tx_done && !(auto_rel && tx_ok);
        m_br   = tx_done && auto_rel && tx_ok;
        m_st   = next_arm();
        if (mask_we) m_mask = mask_wdata;
    endtask

    task automatic compare_all();
        chk("R2 rx bit",      {7'd0, status[0]}, {7'd0, m_stat[0]});
        chk("R3 tx bit",      {7'd0, status[1]}, {7'd0, m_stat[1]});
        chk("R4 R9 txe bit",  {7'd0, status[2]}, {7'd0, m_stat[2]});
        chk("R6 reserved",    {3'd0, status[7:3]}, 8'd0);
        chk("R5 irq",         {7'd0, irq}, {7'd0, m_irq});
        chk("R10 mask",       mask, m_mask);
        chk("R7 R8 push",     {7'd0, cmpl_push}, {7'd0, m_cp});
        chk("R7 R8 release",  {7'd0, buf_release}, {7'd0, m_br});
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        mask_we = 1'b0;
        tx_done = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] v);
        mask_we    = 1'b1;
        mask_wdata = v;
        step();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", status, 8'd0);
        chk("R1 mask", mask, 8'd0);
        chk("R1 irq/push/rel", {5'd0, irq, cmpl_push, buf_release}, 8'd0);
        rst_n = 1'b1;
        step();
        chk("R1 first cycle irq", {7'd0, irq}, 8'd0);

        // R4: enabling tx-empty with an empty pending queue raises nothing
        wr_mask(8'h04);
        repeat (4) step();
        chk("R4 no startup txe", {7'd0, status[2]}, 8'd0);
        chk("R4 no startup irq", {7'd0, irq}, 8'd0);
        txp_cnt = 5'd3; step();
        txp_cnt = 5'd0; step();
        chk("R4 txe after batch", {7'd0, status[2]}, 8'd1);
        chk("R5 irq from txe", {7'd0, irq}, 8'd1);

        // R9: disable then re-enable needs a fresh packet
        wr_mask(8'h00); step();
        wr_mask(8'h04);
        repeat (3) step();
        chk("R9 rearm required", {7'd0, status[2]}, 8'd0);

        // R6: mask write does not clear a live rx level
        rx_cnt = 5'd2; step();
        wr_mask(8'h01);
        chk("R6 rx held over write", {7'd0, status[0]}, 8'd1);
        step();
        chk("R5 rx irq", {7'd0, irq}, 8'd1);
        rx_cnt = 5'd0; step();
        chk("R2 rx drops", {7'd0, status[0]}, 8'd0);

        // R7 / R8 directed
        auto_rel = 1'b0; tx_done = 1'b1; tx_ok = 1'b1; step();
        chk("R7 push on ok", {6'd0, cmpl_push, buf_release}, 8'b10);
        auto_rel = 1'b1; tx_done = 1'b1; tx_ok = 1'b1; step();
        chk("R8 release on ok", {6'd0, cmpl_push, buf_release}, 8'b01);
        tx_done = 1'b1; tx_ok = 1'b0; step();
        chk("R8 push on fail", {6'd0, cmpl_push, buf_release}, 8'b10);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            rx_cnt   = ($urandom % 3 == 0) ? CNT_W'($urandom) : '0;
            txp_cnt  = ($urandom % 2 == 0) ? CNT_W'($urandom) : '0;
            txc_cnt  = ($urandom % 3 == 0) ? CNT_W'($urandom) : '0;
            auto_rel = ($urandom % 4 != 0);
            tx_done  = ($urandom % 3 == 0);
            tx_ok    = ($urandom % 4 != 0);
            if ($urandom % 16 == 0) begin
                mask_we    = 1'b1;
                mask_wdata = 8'($urandom);
            end
            step();
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule